// File: doc/BRIEF.md
# I2S Bus-Master Clock Generator

This block produces the bit clock, the word-select strobe and an optional master clock for an I2S link on which the chip is the clock master. All three outputs are registered in the domain of one fast source clock. The source clock either acts as the master clock directly, or, with no master clock, sets the bit-clock rate on its own. The rest of the audio path uses the word-select timing to place its samples.

Software-side logic loads a configuration word while the generator is idle: the sample length code, a flag that shrinks the slot from 32 to 24 bits for 18, 20 or 24-bit samples, a master-clock enable and a ratio field N. With the master clock enabled, a frame lasts 16*(N+1) master-clock periods. A start strobe launches the clocks. A stop strobe lets the current frame finish, so the outputs always come to rest in a clean idle state. A configuration whose ratio cannot be met is flagged and never started.

Top module: `i2s_clkgen`

## Requirements
- R1: After reset the stored configuration is all zeros (length code 0, 32-bit slot, master clock off, ratio 0), every output is low and cfg_err_o is low.
- R2: A configuration write is taken only while running_o is low. A write issued while running leaves the clocks, word select and error flag unchanged.
- R3: The slot width follows the length code: 0 gives 32 bits; 1, 2 and 3 (24, 20 and 18-bit samples) give 32 bits when slot24 is 0 and 24 bits when it is 1; 4 gives 16 bits; 5 gives 8 bits.
- R4: With the master clock off, mclk_o stays low and sck_o toggles on every source-clock edge (half-period of one source cycle).
- R5: With the master clock on, mclk_o toggles on every source-clock edge. sck_o has a half-period of D source cycles, where D = 16*(N+1)/(2*slot), so that one frame lasts 16*(N+1) master-clock periods.
- R6: cfg_err_o is high when the length code is 6 or 7, or when the master clock is on and 16*(N+1) is not a multiple of 2*slot, or when it is on and D equals 1. While it is high, start_i is ignored.
- R7: ws_o is low for the first slot and high for the second slot of each frame, and it changes only on a falling edge of sck_o.
- R8: A start strobe while idle with no error sets running_o on the next edge. k source edges later, sck_o = (k/D) mod 2, ws_o = (k/(2*D*slot)) mod 2, and mclk_o = k mod 2 when the master clock is on.
- R9: After a stop strobe, the clocks run until the end of the current frame. running_o falls on the edge where ws_o returns low, and sck_o, ws_o and mclk_o are all low from then on.
- R10: running_o is high from the start edge until the stop takes effect, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| arst_n_i | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_dlen_i | input | 3 | Sample length code |
| cfg_slot24_i | input | 1 | Shrink slot to 24 bits for 18/20/24-bit samples |
| cfg_mclk_en_i | input | 1 | Source clock drives the master clock |
| cfg_ratio_i | input | RATIO_W | Ratio field N |
| start_i | input | 1 | Start strobe |
| stop_i | input | 1 | Stop strobe |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| mclk_o | output | 1 | Master clock |
| running_o | output | 1 | Clocks are active |
| cfg_err_o | output | 1 | Stored configuration cannot be generated |

## Verification
The assertions assume that strobes are single-cycle and synchronous to clk_i, and that the reset input is held low for at least two source edges. A configuration register frozen while running is not taken for granted: a checker property watches it. The bench drives every strobe for exactly one cycle from the inactive clock edge. It issues a stop right after each start, so that every legal configuration runs exactly one frame. In the second cycle of each run it writes a deliberately different configuration, which the frozen-configuration rule must absorb.

// File: rtl/i2s_clkgen_pkg.sv
package i2s_clkgen_pkg;

  localparam int SLOT_W = 6;

  localparam logic [2:0] DLEN_32 = 3'd0;
  localparam logic [2:0] DLEN_24 = 3'd1;
  localparam logic [2:0] DLEN_20 = 3'd2;
  localparam logic [2:0] DLEN_18 = 3'd3;
  localparam logic [2:0] DLEN_16 = 3'd4;
  localparam logic [2:0] DLEN_8  = 3'd5;

  typedef enum logic [1:0] {SLOT_8, SLOT_16, SLOT_24, SLOT_32} slot_e;

  function automatic slot_e slot_pick(logic [2:0] dl, logic s24);
    slot_e s;
    case (dl)
      DLEN_24, DLEN_20, DLEN_18: s = s24 ? SLOT_24 : SLOT_32;
      DLEN_16:                   s = SLOT_16;
      DLEN_8:                    s = SLOT_8;
      default:                   s = SLOT_32;
    endcase
    return s;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_bits(slot_e s);
    logic [SLOT_W-1:0] b;
    case (s)
      SLOT_8:  b = SLOT_W'(8);
      SLOT_16: b = SLOT_W'(16);
      SLOT_24: b = SLOT_W'(24);
      default: b = SLOT_W'(32);
    endcase
    return b;
  endfunction

  function automatic logic dlen_bad(logic [2:0] dl);
    return dl > DLEN_8;
  endfunction

endpackage

// File: rtl/i2s_rst_sync.sv
module i2s_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/i2s_cfg_unit.sv
module i2s_cfg_unit
  import i2s_clkgen_pkg::*;
#(
  parameter int RATIO_W = 4,
  parameter int DIV_W   = RATIO_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         dlen_d,
  input  logic               s24_d,
  input  logic               mck_d,
  input  logic [RATIO_W-1:0] ratio_d,
  output logic               mck_q,
  output logic [SLOT_W-1:0]  slot_len,
  output logic [DIV_W-1:0]   half_div,
  output logic               err
);
  logic [2:0]         dlen_q, dlen_n;
  logic               s24_q, s24_n, mck_n;
  logic [RATIO_W-1:0] ratio_q, ratio_n;

  always_comb begin
    dlen_n  = dlen_q;
    s24_n   = s24_q;
    mck_n   = mck_q;
    ratio_n = ratio_q;
    if (wr_en) begin
      dlen_n  = dlen_d;
      s24_n   = s24_d;
      mck_n   = mck_d;
      ratio_n = ratio_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlen_q  <= '0;
      s24_q   <= 1'b0;
      mck_q   <= 1'b0;
      ratio_q <= '0;
    end else begin
      dlen_q  <= dlen_n;
      s24_q   <= s24_n;
      mck_q   <= mck_n;
      ratio_q <= ratio_n;
    end
  end

  // Frame = 16*(N+1) master periods = 2*slot bit periods = 4*slot*D source cycles.
  localparam logic [DIV_W-1:0] THREE = DIV_W'(3);
  localparam logic [DIV_W-1:0] ONE   = DIV_W'(1);

  slot_e            slot;
  logic [DIV_W-1:0] np1, quo;
  logic             exact, bad_len;

  always_comb begin
    slot    = slot_pick(dlen_q, s24_q);
    bad_len = dlen_bad(dlen_q);
    np1     = DIV_W'(ratio_q) + ONE;
    exact   = 1'b1;
    quo     = np1;
    case (slot)
      SLOT_32: begin exact = (np1[1:0] == 2'b00); quo = np1 >> 2; end
      SLOT_24: begin exact = ((np1 % THREE) == '0); quo = np1 / THREE; end
      SLOT_16: begin exact = !np1[0]; quo = np1 >> 1; end
      default: begin exact = 1'b1; quo = np1; end
    endcase
    if (!mck_q) begin
      err      = bad_len;
      half_div = ONE;
    end else begin
      err      = bad_len | !exact | (quo == ONE);
      half_div = err ? ONE : quo;
    end
    slot_len = slot_bits(slot);
  end
endmodule

// File: rtl/i2s_sck_div.sv
module i2s_sck_div #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sck,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             sck_n, wrap;

  assign wrap = (cnt_q == half_div - DIV_W'(1));
  assign fall = run & wrap & sck;

  always_comb begin
    cnt_n = cnt_q;
    sck_n = sck;
    if (!run) begin
      cnt_n = '0;
      sck_n = 1'b0;
    end else if (wrap) begin
      cnt_n = '0;
      sck_n = ~sck;
    end else begin
      cnt_n = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      sck   <= sck_n;
    end
  end
endmodule

// File: rtl/i2s_frame_seq.sv
module i2s_frame_seq #(
  parameter int SLOT_W = 6,
  parameter int BIT_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              fall,
  input  logic [SLOT_W-1:0] slot_len,
  output logic              ws,
  output logic              frame_end
);
  logic [BIT_W-1:0] bit_q, bit_n;
  logic [BIT_W-1:0] half_last, frame_last_v;
  logic             ws_n, at_last;

  assign half_last    = BIT_W'(slot_len) - BIT_W'(1);
  assign frame_last_v = (BIT_W'(slot_len) << 1) - BIT_W'(1);
  assign at_last      = (bit_q == frame_last_v);
  assign frame_end    = fall & at_last;

  always_comb begin
    bit_n = bit_q;
    ws_n  = ws;
    if (!run) begin
      bit_n = '0;
      ws_n  = 1'b0;
    end else if (fall) begin
      if (at_last) begin
        bit_n = '0;
        ws_n  = 1'b0;
      end else begin
        bit_n = bit_q + BIT_W'(1);
        if (bit_q == half_last) ws_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      ws    <= 1'b0;
    end else begin
      bit_q <= bit_n;
      ws    <= ws_n;
    end
  end
endmodule

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_clkgen_pkg::*;
#(
  parameter int RATIO_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               arst_n_i,
  input  logic               cfg_wr_i,
  input  logic [2:0]         cfg_dlen_i,
  input  logic               cfg_slot24_i,
  input  logic               cfg_mclk_en_i,
  input  logic [RATIO_W-1:0] cfg_ratio_i,
  input  logic               start_i,
  input  logic               stop_i,
  output logic               sck_o,
  output logic               ws_o,
  output logic               mclk_o,
  output logic               running_o,
  output logic               cfg_err_o
);
  localparam int DIV_W = RATIO_W + 1;

  logic              rst_sync_n;
  logic              run_q, run_n, stop_pend_q, stop_pend_n;
  logic              mclk_n;
  logic              mck_mode;
  logic [SLOT_W-1:0] slot_len;
  logic [DIV_W-1:0]  half_div;
  logic              sck_fall, frame_end;

  i2s_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_i), .arst_n(arst_n_i), .rst_n(rst_sync_n)
  );

  i2s_cfg_unit #(.RATIO_W(RATIO_W), .DIV_W(DIV_W)) u_cfg (
    .clk(clk_i), .rst_n(rst_sync_n), .wr_en(cfg_wr_i & ~run_q),
    .dlen_d(cfg_dlen_i), .s24_d(cfg_slot24_i), .mck_d(cfg_mclk_en_i),
    .ratio_d(cfg_ratio_i), .mck_q(mck_mode), .slot_len(slot_len),
    .half_div(half_div), .err(cfg_err_o)
  );

  i2s_sck_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk_i), .rst_n(rst_sync_n), .run(run_q), .half_div(half_div),
    .sck(sck_o), .fall(sck_fall)
  );

  i2s_frame_seq #(.SLOT_W(SLOT_W)) u_seq (
    .clk(clk_i), .rst_n(rst_sync_n), .run(run_q), .fall(sck_fall),
    .slot_len(slot_len), .ws(ws_o), .frame_end(frame_end)
  );

  always_comb begin
    run_n       = run_q;
    stop_pend_n = stop_pend_q;
    if (!run_q) begin
      stop_pend_n = 1'b0;
      run_n       = start_i & ~cfg_err_o;
    end else begin
      if (stop_i) stop_pend_n = 1'b1;
      if (frame_end && (stop_pend_q || stop_i)) begin
        run_n       = 1'b0;
        stop_pend_n = 1'b0;
      end
    end
    mclk_n = (run_q & run_n & mck_mode) ? ~mclk_o : 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      mclk_o      <= 1'b0;
    end else begin
      run_q       <= run_n;
      stop_pend_q <= stop_pend_n;
      mclk_o      <= mclk_n;
    end
  end

  assign running_o = run_q;
endmodule

// File: rtl/i2s_clkgen_chk.sv
module i2s_clkgen_chk #(
  parameter int SLOT_W = 6,
  parameter int DIV_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              sck,
  input logic              ws,
  input logic              mclk,
  input logic              err,
  input logic              mck_mode,
  input logic [SLOT_W-1:0] slot_len,
  input logic [DIV_W-1:0]  half_div
);
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) |-> $stable(slot_len) && $stable(half_div) && $stable(mck_mode)); // R2

  AST_MCLK_QUIET_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    !mck_mode |-> !mclk); // R4

  AST_MCLK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    run && $past(run) && mck_mode |-> mclk != $past(mclk)); // R5

  AST_NO_RUN_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !err); // R6

  AST_WS_ON_SCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> $fell(sck)); // R7

  AST_STOP_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> $past(ws) && !ws && !sck); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !sck && !ws && !mclk); // R10
endmodule

bind i2s_clkgen i2s_clkgen_chk #(.SLOT_W(i2s_clkgen_pkg::SLOT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk_i), .rst_n(rst_sync_n), .run(running_o), .sck(sck_o), .ws(ws_o),
  .mclk(mclk_o), .err(cfg_err_o), .mck_mode(mck_mode), .slot_len(slot_len),
  .half_div(half_div)
);

// File: tb/tb_i2s_clkgen.sv
module tb_i2s_clkgen;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       cfg_wr = 1'b0, slot24 = 1'b0, mclk_en = 1'b0;
  logic [2:0] dlen = '0;
  logic [3:0] ratio = '0;
  logic       start = 1'b0, stop = 1'b0;
  logic       sck, ws, mclk, running, err;
  int         n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  i2s_clkgen dut (
    .clk_i(clk), .arst_n_i(arst_n), .cfg_wr_i(cfg_wr), .cfg_dlen_i(dlen),
    .cfg_slot24_i(slot24), .cfg_mclk_en_i(mclk_en), .cfg_ratio_i(ratio),
    .start_i(start), .stop_i(stop), .sck_o(sck), .ws_o(ws), .mclk_o(mclk),
    .running_o(running), .cfg_err_o(err)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic int slot_of(int dl, int s24);
    case (dl)
      1, 2, 3: return s24 ? 24 : 32;
      4:       return 16;
      5:       return 8;
      default: return 32;
    endcase
  endfunction

  // Returns half-period D of the bit clock, or 0 when the setup is illegal.
  function automatic int div_of(int dl, int s24, int m, int n);
    int r, s2;
    if (dl > 5) return 0;
    if (m == 0) return 1;
    r  = 16 * (n + 1);
    s2 = 2 * slot_of(dl, s24);
    if (r % s2 != 0) return 0;
    if (r / s2 == 1) return 0;
    return r / s2;
  endfunction

  task automatic write_cfg(int dl, int s24, int m, int n);
    @(negedge clk);
    dlen = 3'(dl); slot24 = 1'(s24); mclk_en = 1'(m); ratio = 4'(n); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Starts with the stored setup, stops at once, compares one full frame.
  task automatic run_one(int dl, int s24, int m, int n);
    int d, sl, f;
    d  = div_of(dl, s24, m, n);
    sl = slot_of(dl, s24);
    chk("R6 cfg_err", int'(err), (d == 0) ? 1 : 0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (d == 0) begin
      chk("R6 start ignored", int'(running), 0);
      @(negedge clk);
      chk("R6 still idle", int'({running, sck, ws, mclk}), 0);
      return;
    end
    stop = 1'b1;
    chk("R8 running after start", int'(running), 1);
    chk("R8 first state", int'({sck, ws, mclk}), 0);
    f = 4 * sl * d;
    for (int k = 1; k <= f; k++) begin
      @(negedge clk);
      stop = 1'b0;
      if (k == 1) begin
        dlen = ~dlen; slot24 = ~slot24; mclk_en = ~mclk_en; ratio = ~ratio; cfg_wr = 1'b1;
      end else cfg_wr = 1'b0;
      if (k < f) begin
        chk("R10 running", int'(running), 1);
        chk("R2/R5 sck", int'(sck), (k / d) % 2);
        chk("R3/R7 ws", int'(ws), (k / (2 * d * sl)) % 2);
        chk("R4/R5 mclk", int'(mclk), m ? (k % 2) : 0);
        chk("R2 cfg_err frozen", int'(err), 0);
      end else begin
        chk("R9 stop at frame end", int'({running, sck, ws, mclk}), 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R10 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset outputs", int'({running, sck, ws, mclk, err}), 0);
    run_one(0, 0, 0, 0);
    for (int m = 0; m < 2; m++)
      for (int dl = 0; dl < 8; dl++)
        for (int s = 0; s < 2; s++)
          for (int n = 0; n < 16; n++) begin
            write_cfg(dl, s, m, n);
            run_one(dl, s, m, n);
          end
    summary();
    $finish;
  end
endmodule